// File: doc/BRIEF.md
# Register Write Guard

This block stands between a peripheral's register bus and its configuration registers and decides, write by write, whether a target register may be updated. A single enable bit in a mode register switches protection on. While it is set, writes aimed at a parameter-selected subset of the target registers are refused: the block raises no write enable toward that register, and the bus completes the transfer as usual with no error indication.

Each refused write is logged in a status register. The log holds a sticky violation flag and the index of the register that the write was aimed at. Reading the status register returns both values and clears the flag in the same cycle. The mode register only accepts a new value when the upper bits of the written word carry a fixed key constant. The mode and status registers are local to the guard and are never subject to protection.

Reads and writes arrive on separate address channels, so a status read and a new violation can fall in the same cycle. Read data is registered and appears one clock after the read strobe.

Top module: `wp_guard`

## Requirements
- R1: After reset, with the default reset enable of 0, the mode read value, the status read value, `rd_data` and `reg_we` are all zero.
- R2: A write to target index i (0 to NUM_REGS-1) that is not refused raises exactly bit i of `reg_we` in the same cycle as `wr_stb`. At most one bit of `reg_we` is ever high.
- R3: While protection is enabled, a write to a target index whose bit in PROT_MASK (default 8'h3C, so indices 2 to 5) is 1 raises no `reg_we` bit. Writes to unmasked indices still pass.
- R4: A refused write sets the status flag (status bit 0) and stores the target index in status bits [8 +: ADDR_W]. A status read returns these values one cycle after the read strobe.
- R5: A status read clears the flag. The stored index is kept, so the next read returns a 0 flag and the old index.
- R6: If a second write is refused before the status is read, the stored index becomes the index of the latest refused write.
- R7: If a status read and a refused write fall in the same cycle, the read returns the values from before that write. The flag stays set and the stored index takes the new value.
- R8: A write to the mode index (NUM_REGS, default 8) updates the enable bit from data bit 0 only when data bits [31:8] equal KEY (default 24'hA5C3E1). With any other key, the write is ignored. The mode read value is the enable in bit 0 and zeros elsewhere.
- R9: Writes to the mode index and to the status index (NUM_REGS+1, default 9) are never refused. They raise no `reg_we` bit and never set the flag. Protection can be switched off again with a keyed mode write.
- R10: Reads from any index other than mode and status return zero. Writes to indices at or above NUM_REGS+2 raise no `reg_we` bit and leave the flag alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr | input | ADDR_W | Write register index |
| wr_data | input | DATA_W | Write data |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_addr | input | ADDR_W | Read register index |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_data | output | DATA_W | Registered read data, valid one cycle after `rd_stb` |
| reg_we | output | NUM_REGS | Per-target write enable |
| tgt_data | output | DATA_W | Write data forwarded to the targets |

## Verification
The hardest case to reach is a status read and a new refused write landing on the same clock edge. At that edge, clearing the flag and setting it compete. The bench reaches this case by driving both strobes in one cycle on the two independent address channels. It then checks that the read returns the old index and that a follow-up read shows the flag still set with the new index. Reaching the refusal path at all first requires a mode write with the correct key. The bench also shows that a wrong key leaves protection off.

// File: rtl/wp_pkg.sv
package wp_pkg;
   // status word layout
   localparam int STAT_FLAG_BIT = 0;
   localparam int STAT_SRC_LSB  = 8;
   // mode word layout
   localparam int MODE_EN_BIT   = 0;
   localparam int MODE_KEY_LSB  = 8;
endpackage

// File: rtl/wp_decode.sv
module wp_decode #(
   parameter int                ADDR_W    = 4,
   parameter int                NUM_REGS  = 8,
   parameter logic [NUM_REGS-1:0] PROT_MASK = '0
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] tgt_hit,
   output logic                hit_mode,
   output logic                hit_stat,
   output logic                hit_prot
);
   localparam logic [ADDR_W-1:0] MODE_IDX = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(NUM_REGS + 1);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
      assign tgt_hit[g] = (addr == ADDR_W'(g));
   end

   assign hit_mode = (addr == MODE_IDX);
   assign hit_stat = (addr == STAT_IDX);
   assign hit_prot = |(tgt_hit & PROT_MASK);
endmodule

// File: rtl/wp_mode.sv
module wp_mode #(
   parameter int             KEY_W  = 24,
   parameter logic [KEY_W-1:0] KEY  = '0,
   parameter bit             EN_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [KEY_W-1:0] key_in,
   input  logic             en_in,
   output logic             en
);
   logic key_ok;
   assign key_ok = (key_in == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            en <= EN_RST;
      else if (wr && key_ok) en <= en_in;
   end
endmodule

// File: rtl/wp_status.sv
module wp_status #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              viol,
   input  logic              rd_clr,
   input  logic [ADDR_W-1:0] viol_addr,
   output logic              flag,
   output logic [ADDR_W-1:0] src
);
   // a new violation wins over a clearing read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (viol) begin
         flag <= 1'b1;
         src  <= viol_addr;
      end else if (rd_clr) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
   parameter int                  ADDR_W    = 4,
   parameter int                  DATA_W    = 32,
   parameter int                  NUM_REGS  = 8,
   parameter logic [NUM_REGS-1:0] PROT_MASK = 8'h3C,
   parameter int                  KEY_W     = 24,
   parameter logic [KEY_W-1:0]    KEY       = 24'hA5C3E1,
   parameter bit                  EN_RST    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                wr_stb,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic                rd_stb,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_REGS-1:0] reg_we,
   output logic [DATA_W-1:0]   tgt_data
);
   import wp_pkg::*;

   localparam logic [ADDR_W-1:0] MODE_IDX = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(NUM_REGS + 1);

   if (NUM_REGS < 1)
      $error("wp_guard: NUM_REGS must be at least 1");
   if (NUM_REGS + 2 > (1 << ADDR_W))
      $error("wp_guard: ADDR_W too narrow for targets plus mode and status");
   if (DATA_W < MODE_KEY_LSB + KEY_W)
      $error("wp_guard: DATA_W cannot hold the key field");
   if (DATA_W < STAT_SRC_LSB + ADDR_W)
      $error("wp_guard: DATA_W cannot hold the source field");

   logic [NUM_REGS-1:0] tgt_hit;
   logic                wr_mode, wr_stat, wr_prot;
   logic                en_q, viol, rd_clr;
   logic                viol_flag;
   logic [ADDR_W-1:0]   viol_src;
   logic [DATA_W-1:0]   rd_next;

   wp_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PROT_MASK(PROT_MASK)
   ) i_dec (
      .addr(wr_addr), .tgt_hit(tgt_hit), .hit_mode(wr_mode),
      .hit_stat(wr_stat), .hit_prot(wr_prot)
   );

   wp_mode #(
      .KEY_W(KEY_W), .KEY(KEY), .EN_RST(EN_RST)
   ) i_mode (
      .clk(clk), .rst_n(rst_n), .wr(wr_stb && wr_mode),
      .key_in(wr_data[MODE_KEY_LSB +: KEY_W]),
      .en_in(wr_data[MODE_EN_BIT]), .en(en_q)
   );

   assign viol   = wr_stb && en_q && wr_prot;
   assign rd_clr = rd_stb && (rd_addr == STAT_IDX);

   wp_status #(.ADDR_W(ADDR_W)) i_stat (
      .clk(clk), .rst_n(rst_n), .viol(viol), .rd_clr(rd_clr),
      .viol_addr(wr_addr), .flag(viol_flag), .src(viol_src)
   );

   // status index is local: its writes are accepted and have no effect
   logic stat_wr_unused;
   assign stat_wr_unused = wr_stat;

   assign reg_we   = (wr_stb && !viol) ? tgt_hit : '0;
   assign tgt_data = wr_data;

   always_comb begin
      rd_next = '0;
      if (rd_addr == MODE_IDX) begin
         rd_next[MODE_EN_BIT] = en_q;
      end else if (rd_addr == STAT_IDX) begin
         rd_next[STAT_FLAG_BIT]              = viol_flag;
         rd_next[STAT_SRC_LSB +: ADDR_W]     = viol_src;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= rd_next;
   end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
   parameter int                  ADDR_W    = 4,
   parameter int                  DATA_W    = 32,
   parameter int                  NUM_REGS  = 8,
   parameter logic [NUM_REGS-1:0] PROT_MASK = '0,
   parameter int                  KEY_W     = 24,
   parameter logic [KEY_W-1:0]    KEY       = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic                wr_stb,
   input logic [ADDR_W-1:0]   rd_addr,
   input logic                rd_stb,
   input logic [NUM_REGS-1:0] reg_we,
   input logic                en,
   input logic                flag,
   input logic [ADDR_W-1:0]   src
);
   localparam logic [ADDR_W-1:0] MODE_IDX = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(NUM_REGS + 1);

   logic [NUM_REGS-1:0] mask_sh;
   logic prot, refuse, bad_key;
   assign mask_sh = PROT_MASK >> wr_addr;
   assign prot    = (int'(wr_addr) < NUM_REGS) && mask_sh[0];
   assign refuse  = wr_stb && en && prot;
   assign bad_key = wr_data[8 +: KEY_W] != KEY;

   assert_we_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we));

   assert_refused_no_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |-> (reg_we == '0));

   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (flag && src == $past(wr_addr)));

   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_addr == STAT_IDX && !refuse) |=> !flag);

   assert_bad_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == MODE_IDX && bad_key) |=> $stable(en));

   assert_local_no_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (wr_addr == MODE_IDX || wr_addr == STAT_IDX)) |-> (reg_we == '0));
endmodule

bind wp_guard wp_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
   .PROT_MASK(PROT_MASK), .KEY_W(KEY_W), .KEY(KEY)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
   .wr_stb(wr_stb), .rd_addr(rd_addr), .rd_stb(rd_stb), .reg_we(reg_we),
   .en(en_q), .flag(viol_flag), .src(viol_src)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
   localparam int PERIOD = 10;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int NREG   = 8;
   localparam logic [23:0] KEY = 24'hA5C3E1;
   localparam logic [ADDR_W-1:0] MODE = 4'd8;
   localparam logic [ADDR_W-1:0] STAT = 4'd9;

   logic              clk = 0, rst_n = 0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_stb = 0, rd_stb = 0;
   logic [DATA_W-1:0] rd_data, tgt_data;
   logic [NREG-1:0]   reg_we;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   wp_guard i_wp_guard (
      .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_stb(wr_stb), .rd_addr(rd_addr), .rd_stb(rd_stb),
      .rd_data(rd_data), .reg_we(reg_we), .tgt_data(tgt_data)
   );

   task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] stat_word(bit f, int s);
      return DATA_W'(f) | (DATA_W'(s) << 8);
   endfunction

   // write; reg_we is checked inside the strobe cycle
   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                     input logic [NREG-1:0] we_exp, input string req);
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_stb = 1;
      #1 check(req, DATA_W'(reg_we), DATA_W'(we_exp));
      @(negedge clk);
      wr_stb = 0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
      @(negedge clk);
      rd_addr = a; rd_stb = 1;
      @(negedge clk);
      rd_stb = 0;
      v = rd_data;
   endtask

   task automatic set_prot(bit on);
      wr(MODE, {KEY, 7'd0, on}, '0, "R9");
   endtask

   task automatic t_reset;
      logic [DATA_W-1:0] v;
      check("R1", rd_data, '0);
      check("R1", DATA_W'(reg_we), '0);
      rd(MODE, v); check("R1", v, '0);
      rd(STAT, v); check("R1", v, '0);
   endtask

   task automatic t_open;
      logic [DATA_W-1:0] v;
      for (int i = 0; i < NREG; i++)
         wr(ADDR_W'(i), 32'h1234_0000 + i, NREG'(1) << i, "R2");
      rd(STAT, v); check("R2", v, stat_word(0, 0));
   endtask

   task automatic t_key;
      logic [DATA_W-1:0] v;
      wr(MODE, {24'hA5C3E0, 8'h01}, '0, "R8");
      rd(MODE, v); check("R8", v, 32'd0);
      wr(3, 32'h0, 8'h08, "R8");
      set_prot(1);
      rd(MODE, v); check("R8", v, 32'd1);
   endtask

   task automatic t_block;
      logic [DATA_W-1:0] v;
      wr(3, 32'hDEAD, '0, "R3");
      wr(1, 32'hBEEF, 8'h02, "R3");
      wr(6, 32'hBEEF, 8'h40, "R3");
      rd(STAT, v); check("R4", v, stat_word(1, 3));
      rd(STAT, v); check("R5", v, stat_word(0, 3));
   endtask

   task automatic t_latest;
      logic [DATA_W-1:0] v;
      wr(2, 32'h1, '0, "R6");
      wr(5, 32'h2, '0, "R6");
      rd(STAT, v); check("R6", v, stat_word(1, 5));
   endtask

   task automatic t_same;
      logic [DATA_W-1:0] v;
      wr(4, 32'h0, '0, "R7");
      @(negedge clk);
      wr_addr = 2; wr_data = 32'h5; wr_stb = 1;
      rd_addr = STAT; rd_stb = 1;
      #1 check("R7", DATA_W'(reg_we), '0);
      @(negedge clk);
      wr_stb = 0; rd_stb = 0;
      check("R7", rd_data, stat_word(1, 4));
      rd(STAT, v); check("R7", v, stat_word(1, 2));
   endtask

   task automatic t_local;
      logic [DATA_W-1:0] v;
      wr(STAT, 32'hFFFF_FFFF, '0, "R9");
      rd(STAT, v); check("R9", v, stat_word(0, 2));
      set_prot(0);
      rd(MODE, v); check("R9", v, 32'd0);
      rd(STAT, v); check("R9", v, stat_word(0, 2));
      wr(3, 32'h7, 8'h08, "R9");
   endtask

   task automatic t_other;
      logic [DATA_W-1:0] v;
      set_prot(1);
      rd(3, v);  check("R10", v, '0);
      rd(12, v); check("R10", v, '0);
      wr(12, 32'h9, '0, "R10");
      wr(15, 32'h9, '0, "R10");
      rd(STAT, v); check("R10", v, stat_word(0, 2));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 20000);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_open();
      t_key();
      t_block();
      t_latest();
      t_same();
      t_local();
      t_other();
      finish_run();
   end
endmodule